// File: doc/BRIEF.md
# Clock-Distributor Power-Up Configuration Sequencer

This block brings an external clock-distribution device out of reset and loads its nine configuration registers. After a start pulse it first puts the device through a timed bring-up. Power-down is held low for one wait interval, then released. After a second interval the sync line is pulsed low for one interval. A final interval passes before any serial traffic.

It then writes one 32-bit frame per register over a write-only, three-wire serial link: clock, data and active-low chip enable. The frames go out in ascending address order. Each frame carries the register address in its four low bits and the 28-bit register value above them, and it is shifted out least-significant bit first.

Two constant register sets are held as parameters, one for a primary and one for a secondary reference input. A select input, sampled when the sequence is accepted, picks which set is sent. A busy flag covers the whole run and a one-cycle done pulse marks its end.

Top module: `clkdist_cfg_seq`

## Requirements
- R1: After reset, sclk is 0, cs_n is 1, pd_n is 1, sync_n is 1, busy is 0 and done is 0.
- R2: A start pulse sampled while idle sets busy and drives pd_n low in the next cycle, and pd_n then stays low for exactly WAIT_CYCLES cycles.
- R3: WAIT_CYCLES cycles after pd_n rises, sync_n goes low for exactly WAIT_CYCLES cycles. At least WAIT_CYCLES cycles follow before cs_n first falls. pd_n and sync_n are never low together, and cs_n is never low while either of them is low.
- R4: Each frame is exactly 32 sclk rising edges while cs_n is low. The frame word is {value[27:0], address[3:0]}, bit 0 is sent first, and the device takes each bit on the sclk rising edge. sdata does not change while sclk is high.
- R5: sclk stays high for exactly SCK_HI system cycles per bit and low for at least SCK_LO cycles. sclk is 0 whenever cs_n is 1.
- R6: One run sends nine frames with addresses 0 through 8 in ascending order. The values come from the primary table when ref_sel is 0 and from the secondary table when ref_sel is 1, as sampled with the accepted start.
- R7: Between two frames of a run, cs_n stays high for at least SCK_LO+SCK_HI cycles.
- R8: busy stays high until after cs_n rises at the end of the ninth frame. done is then high for exactly one cycle, in the same cycle that busy first reads 0.
- R9: A start pulse while busy is ignored: the run continues unchanged, ref_sel is not re-sampled and no extra run follows.
- R10: A start pulse sampled in the cycle in which done is high is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the bring-up sequence |
| ref_sel | input | 1 | Register set select: 0 primary, 1 secondary |
| sclk | output | 1 | Serial clock to the device |
| sdata | output | 1 | Serial data to the device |
| cs_n | output | 1 | Active-low chip enable |
| pd_n | output | 1 | Active-low power-down |
| sync_n | output | 1 | Active-low sync |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence completion |

## Verification
Completion of a run and acceptance of a new request can fall in the same cycle. The bench provokes this by raising start in exactly the cycle where done reads high. It then expects busy and a low pd_n one cycle later, followed by a full second set of frames. A start that arrives mid-frame, together with a changed ref_sel, is judged the other way: the frame scoreboard must still match the originally selected table, and no extra run may appear afterwards.

// File: rtl/clkdist_cfg_pkg.sv
package clkdist_cfg_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PWRDN,
    SQ_PWRUP,
    SQ_SYNC,
    SQ_SETTLE,
    SQ_LOAD,
    SQ_SEND,
    SQ_GAP
  } seq_state_t;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_LOW,
    TX_HIGH,
    TX_TAIL
  } tx_state_t;

endpackage

// File: rtl/clkdist_cfg_rom.sv
module clkdist_cfg_rom #(
  parameter int NUM_REGS = 9,
  parameter int DATA_W   = 28,
  parameter int ADDR_W   = 4,
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] PRI_TABLE = '0,
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] SEC_TABLE = '0
) (
  input  logic              clk,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rd_data
);

  // Registered read so the two constant tables map onto a ROM.
  always_ff @(posedge clk) begin
    if (32'(addr) >= NUM_REGS)
      rd_data <= '0;
    else if (sel)
      rd_data <= SEC_TABLE[addr];
    else
      rd_data <= PRI_TABLE[addr];
  end

endmodule

// File: rtl/clkdist_cfg_tx.sv
module clkdist_cfg_tx
  import clkdist_cfg_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int SCK_LO  = 2,
  parameter int SCK_HI  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               sclk,
  output logic               sdata,
  output logic               cs_n,
  output logic               fin
);

  localparam int PH_MAX = (SCK_LO > SCK_HI) ? SCK_LO : SCK_HI;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int BIT_W  = $clog2(FRAME_W);
  localparam logic [PH_W-1:0]  LO_RELOAD = PH_W'(SCK_LO - 1);
  localparam logic [PH_W-1:0]  HI_RELOAD = PH_W'(SCK_HI - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_W - 1);

  tx_state_t          st;
  logic [PH_W-1:0]    ph_cnt;
  logic [BIT_W-1:0]   bit_idx;
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= TX_IDLE;
      ph_cnt  <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      sclk    <= 1'b0;
      sdata   <= 1'b0;
      cs_n    <= 1'b1;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      unique case (st)
        TX_IDLE: begin
          if (load) begin
            cs_n    <= 1'b0;
            sdata   <= frame[0];
            shreg   <= frame >> 1;
            bit_idx <= '0;
            ph_cnt  <= LO_RELOAD;
            st      <= TX_LOW;
          end
        end
        TX_LOW: begin
          if (ph_cnt == '0) begin
            sclk   <= 1'b1;
            ph_cnt <= HI_RELOAD;
            st     <= TX_HIGH;
          end else begin
            ph_cnt <= ph_cnt - 1'b1;
          end
        end
        TX_HIGH: begin
          if (ph_cnt == '0) begin
            sclk   <= 1'b0;
            ph_cnt <= LO_RELOAD;
            if (bit_idx == LAST_BIT) begin
              st <= TX_TAIL;
            end else begin
              sdata   <= shreg[0];
              shreg   <= shreg >> 1;
              bit_idx <= bit_idx + 1'b1;
              st      <= TX_LOW;
            end
          end else begin
            ph_cnt <= ph_cnt - 1'b1;
          end
        end
        TX_TAIL: begin
          if (ph_cnt == '0) begin
            cs_n  <= 1'b1;
            sdata <= 1'b0;
            fin   <= 1'b1;
            st    <= TX_IDLE;
          end else begin
            ph_cnt <= ph_cnt - 1'b1;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clkdist_cfg_seq.sv
module clkdist_cfg_seq
  import clkdist_cfg_pkg::*;
#(
  parameter int NUM_REGS    = 9,
  parameter int DATA_W      = 28,
  parameter int ADDR_W      = 4,
  parameter int WAIT_CYCLES = 14000,
  parameter int SCK_LO      = 2,
  parameter int SCK_HI      = 2,
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] PRI_TABLE = {
    28'h0310A42, 28'h5C00021, 28'h0804D11, 28'h2A80B05, 28'h2A80B04,
    28'h2A80B03, 28'h2A80B02, 28'h2A80B01, 28'h2A80B00},
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] SEC_TABLE = {
    28'h0310A43, 28'h5C00022, 28'h08039E6, 28'h7A80B2C, 28'h7A80B2B,
    28'h7A80B2A, 28'h7A80B29, 28'h7A80B28, 28'h7A80B27}
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ref_sel,
  output logic sclk,
  output logic sdata,
  output logic cs_n,
  output logic pd_n,
  output logic sync_n,
  output logic busy,
  output logic done
);

  localparam int FRAME_W    = DATA_W + ADDR_W;
  localparam int GAP_CYCLES = SCK_LO + SCK_HI;
  localparam int CNT_MAX    = (WAIT_CYCLES > GAP_CYCLES) ? WAIT_CYCLES : GAP_CYCLES;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0]  WAIT_RELOAD = CNT_W'(WAIT_CYCLES - 1);
  localparam logic [CNT_W-1:0]  GAP_RELOAD  = CNT_W'(GAP_CYCLES - 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR   = ADDR_W'(NUM_REGS - 1);

  seq_state_t        st;
  logic [CNT_W-1:0]  wcnt;
  logic [ADDR_W-1:0] addr_q;
  logic              sel_q;
  logic              tx_load;
  logic              tx_fin;
  logic [DATA_W-1:0] rom_data;
  logic [FRAME_W-1:0] frame_word;

  assign frame_word = {rom_data, addr_q};

  clkdist_cfg_rom #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .PRI_TABLE(PRI_TABLE),
    .SEC_TABLE(SEC_TABLE)
  ) rom_i (
    .clk    (clk),
    .sel    (sel_q),
    .addr   (addr_q),
    .rd_data(rom_data)
  );

  clkdist_cfg_tx #(
    .FRAME_W(FRAME_W),
    .SCK_LO (SCK_LO),
    .SCK_HI (SCK_HI)
  ) tx_i (
    .clk  (clk),
    .rst  (rst),
    .load (tx_load),
    .frame(frame_word),
    .sclk (sclk),
    .sdata(sdata),
    .cs_n (cs_n),
    .fin  (tx_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      wcnt    <= '0;
      addr_q  <= '0;
      sel_q   <= 1'b0;
      tx_load <= 1'b0;
      pd_n    <= 1'b1;
      sync_n  <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done    <= 1'b0;
      tx_load <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (start) begin
            sel_q <= ref_sel;
            busy  <= 1'b1;
            pd_n  <= 1'b0;
            wcnt  <= WAIT_RELOAD;
            st    <= SQ_PWRDN;
          end
        end
        SQ_PWRDN: begin
          if (wcnt == '0) begin
            pd_n <= 1'b1;
            wcnt <= WAIT_RELOAD;
            st   <= SQ_PWRUP;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        SQ_PWRUP: begin
          if (wcnt == '0) begin
            sync_n <= 1'b0;
            wcnt   <= WAIT_RELOAD;
            st     <= SQ_SYNC;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        SQ_SYNC: begin
          if (wcnt == '0) begin
            sync_n <= 1'b1;
            wcnt   <= WAIT_RELOAD;
            st     <= SQ_SETTLE;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        SQ_SETTLE: begin
          if (wcnt == '0) begin
            addr_q <= '0;
            st     <= SQ_LOAD;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        SQ_LOAD: begin
          tx_load <= 1'b1;
          st      <= SQ_SEND;
        end
        SQ_SEND: begin
          if (tx_fin) begin
            if (addr_q == LAST_ADDR) begin
              busy <= 1'b0;
              done <= 1'b1;
              st   <= SQ_IDLE;
            end else begin
              wcnt <= GAP_RELOAD;
              st   <= SQ_GAP;
            end
          end
        end
        SQ_GAP: begin
          if (wcnt == '0) begin
            addr_q <= addr_q + 1'b1;
            st     <= SQ_LOAD;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clkdist_cfg_chk.sv
module clkdist_cfg_chk (
  input logic clk,
  input logic rst,
  input logic sclk,
  input logic sdata,
  input logic cs_n,
  input logic pd_n,
  input logic sync_n,
  input logic busy,
  input logic done
);

  // R5: serial clock idles low whenever the device is deselected
  a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R4: data held steady through each high phase
  a_r4_sdata_stable: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdata));

  // R3: power-down and sync never asserted together
  a_r3_pd_sync_apart: assert property (@(posedge clk) disable iff (rst)
    !(!pd_n && !sync_n));

  // R3: no frame while power-down or sync is active
  a_r3_frame_after_release: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> (pd_n && sync_n));

  // R2: a new run opens with power-down asserted
  a_r2_run_opens_pd: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !pd_n);

  // R8: done marks the fall of busy
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R8: done lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind clkdist_cfg_seq clkdist_cfg_chk chk_i (
  .clk   (clk),
  .rst   (rst),
  .sclk  (sclk),
  .sdata (sdata),
  .cs_n  (cs_n),
  .pd_n  (pd_n),
  .sync_n(sync_n),
  .busy  (busy),
  .done  (done)
);

// File: tb/clkdist_cfg_seq_tb.sv
module clkdist_cfg_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 20;
  localparam int LO  = 2;
  localparam int HI  = 3;
  localparam int NREG = 9;
  localparam logic [NREG-1:0][27:0] TB_PRI = {
    28'hA000008, 28'h1234567, 28'hFEDCBA9, 28'h0F0F0F0, 28'h5555555,
    28'hAAAAAAA, 28'h0000001, 28'h8000000, 28'h3C3C3C3};
  localparam logic [NREG-1:0][27:0] TB_SEC = {
    28'h7777777, 28'h0000000, 28'hFFFFFFF, 28'h1111111, 28'h2468ACE,
    28'hC0FFEE1, 28'h9ABCDEF, 28'h0246802, 28'h6DB6DB6};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic ref_sel = 1'b0;
  logic sclk, sdata, cs_n, pd_n, sync_n, busy, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdist_cfg_seq #(
    .NUM_REGS(NREG), .DATA_W(28), .ADDR_W(4), .WAIT_CYCLES(W),
    .SCK_LO(LO), .SCK_HI(HI), .PRI_TABLE(TB_PRI), .SEC_TABLE(TB_SEC)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .ref_sel(ref_sel),
    .sclk(sclk), .sdata(sdata), .cs_n(cs_n), .pd_n(pd_n),
    .sync_n(sync_n), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int frames = 0;
  int dones = 0;
  logic [31:0] exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver side of the scoreboard: expected frames for one run
  task automatic push_run(input logic s);
    for (int i = 0; i < NREG; i++)
      exp_q.push_back(s ? {TB_SEC[i], 4'(i)} : {TB_PRI[i], 4'(i)});
  endtask

  // Monitor: samples outputs at the falling edge
  logic p_pd = 1, p_sync = 1, p_cs = 1, p_sclk = 0, p_sdata = 0, p_done = 0;
  int t_pd_fall, t_pd_rise, t_sync_fall, t_sync_rise, t_cs_rise, t_sclk_rise;
  bit first_frame = 0;
  int nbits = 0;
  logic [31:0] sh = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!pd_n && p_pd) begin t_pd_fall = cyc; first_frame = 1; end
      if (pd_n && !p_pd) begin
        t_pd_rise = cyc;
        chk(cyc - t_pd_fall == W, "R2 pd_n low length", cyc - t_pd_fall, W);
      end
      if (!sync_n && p_sync) begin
        chk(cyc - t_pd_rise == W, "R3 pd release to sync", cyc - t_pd_rise, W);
        t_sync_fall = cyc;
      end
      if (sync_n && !p_sync) begin
        chk(cyc - t_sync_fall == W, "R3 sync low length", cyc - t_sync_fall, W);
        t_sync_rise = cyc;
      end
      if (!pd_n && !sync_n) chk(1'b0, "R3 pd_n and sync_n both low", 0, 1);
      if (!cs_n && p_cs) begin
        if (first_frame)
          chk(cyc - t_sync_rise >= W, "R3 settle before first frame", cyc - t_sync_rise, W);
        else
          chk(cyc - t_cs_rise >= LO + HI, "R7 gap between frames", cyc - t_cs_rise, LO + HI);
        first_frame = 0;
        nbits = 0;
      end
      if (sclk && !p_sclk) begin
        if (cs_n) chk(1'b0, "R5 sclk rose while deselected", 1, 0);
        sh = {sdata, sh[31:1]};
        nbits++;
        t_sclk_rise = cyc;
      end
      if (sclk && p_sclk && sdata != p_sdata) chk(1'b0, "R4 sdata moved while sclk high", sdata, p_sdata);
      if (!sclk && p_sclk)
        chk(cyc - t_sclk_rise == HI, "R5 sclk high length", cyc - t_sclk_rise, HI);
      if (cs_n && !p_cs) begin
        t_cs_rise = cyc;
        frames++;
        chk(nbits == 32, "R4 bits per frame", nbits, 32);
        chk(busy == 1'b1, "R8 busy through frame end", busy, 1);
        if (exp_q.size() == 0) chk(1'b0, "R9 unexpected frame", sh, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(sh == e, "R6 frame content", sh, e);
        end
      end
      if (done) begin
        dones++;
        chk(!busy, "R8 busy low with done", busy, 0);
        if (p_done) chk(1'b0, "R8 done longer than one cycle", 2, 1);
      end
      p_pd = pd_n; p_sync = sync_n; p_cs = cs_n; p_sclk = sclk;
      p_sdata = sdata; p_done = done;
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic pulse_start(input logic s, input string req);
    ref_sel = s;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, req, busy, 1);
    chk(pd_n == 1'b0, req, pd_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(sclk == 0, "R1 sclk", sclk, 0);
    chk(cs_n == 1, "R1 cs_n", cs_n, 1);
    chk(pd_n == 1, "R1 pd_n", pd_n, 1);
    chk(sync_n == 1, "R1 sync_n", sync_n, 1);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0, "R1 done", done, 0);

    // Run 1: primary table (R2, R6)
    push_run(1'b0);
    pulse_start(1'b0, "R2 start accepted");
    wait_done();
    chk(exp_q.size() == 0, "R6 primary run complete", exp_q.size(), 0);

    // Run 2: secondary table, with an ignored mid-frame start and select change (R9)
    repeat (5) @(negedge clk);
    push_run(1'b1);
    pulse_start(1'b1, "R2 start accepted");
    do @(negedge clk); while (cs_n);
    repeat (7) @(negedge clk);
    ref_sel = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(exp_q.size() == 0, "R9 secondary run unaffected", exp_q.size(), 0);
    repeat (3 * W) @(negedge clk);
    chk(busy == 0, "R9 no extra run", busy, 0);
    chk(pd_n == 1, "R9 no extra bring-up", pd_n, 1);

    // Run 3 and 4: start in the same cycle as done (R10)
    push_run(1'b1);
    pulse_start(1'b1, "R2 start accepted");
    wait_done();
    push_run(1'b0);
    pulse_start(1'b0, "R10 start during done");
    wait_done();
    chk(exp_q.size() == 0, "R10 back-to-back runs complete", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    chk(frames == 4 * NREG, "R6 total frames", frames, 4 * NREG);
    chk(dones == 4, "R8 done pulses", dones, 4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule